// File: doc/BRIEF.md
# Reference Rate Classifier and Out-of-Range Monitor

This block watches one reference clock, presented as a single-cycle pulse for each of its rising edges that has already been brought into the master clock domain. It measures how many master clock cycles a fixed number of reference periods span. From that count it decides which of seven nominal rates the reference is running at, with no configuration input. It then judges whether the measured rate lies within a parts-per-million window around that nominal.

The window has hysteresis. A reference that is in range is rejected once its deviation exceeds an upper limit. A reference that has been rejected is accepted again only after two measurement windows in a row fall at or below a lower limit. A single select pin picks one of two limit pairs. If no reference edge arrives for a timeout period, the reference is declared lost at once. Each new result is marked by a one-cycle update strobe.

The master clock rate, the window length in reference edges, the timeout and the ppm limits are parameters. A simulation can therefore run with a scaled-down master clock and short windows.

Top module: `ref_rate_monitor`

## Requirements
- R1: During and after reset, until the first result, `freq_code` is 7, `out_of_range` is 1 and `result_upd` is 0.
- R2: A window is the span of `WIN_EDGES` reference periods. It is measured in master cycles, and consecutive windows share their boundary edge. The code is taken from the nominal count `MCLK_HZ*WIN_EDGES/f` that lies within 1/16 of the measurement. The codes are 0 for 2 kHz, 1 for 8 kHz, 2 for 1.544 MHz, 3 for 2.048 MHz, 4 for 8.192 MHz, 5 for 16.384 MHz and 6 for 19.44 MHz. A rate whose nominal count is below twice `WIN_EDGES` is never chosen.
- R3: A window that matches no nominal gives code 7 with `out_of_range` at 1.
- R4: `result_upd` is high for exactly one cycle, in the cycle after each window completes or the timeout expires. `freq_code` and `out_of_range` change only in such a cycle.
- R5: While in range with an unchanged code, a window whose deviation exceeds 52 ppm (select 0) or 83 ppm (select 1) sets `out_of_range`.
- R6: While flagged, the flag clears only on the second of two consecutive windows with an unchanged code whose deviation is at most 40 ppm (select 0) or 64 ppm (select 1). A flagged window above that limit restarts the count. An in-range window between the two limits leaves the flag clear.
- R7: A window classified to a code other than the current one sets `out_of_range`. If that window is within the lower limit, it counts as the first of the two good windows.
- R8: After `TIMEOUT_CYC` master cycles with no reference edge (default `MCLK_HZ/1000`), the outputs become code 7 and flagged with an update strobe. The next edge only opens a new window.
- R9: `lim_sel` is read when each window completes, so a change takes effect at the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse per reference rising edge, synchronous to `clk` |
| lim_sel | input | 1 | Limit pair select: 0 gives 40/52 ppm, 1 gives 64/83 ppm |
| freq_code | output | 3 | Detected nominal rate code, 7 when none |
| out_of_range | output | 1 | High while the reference is rejected |
| result_upd | output | 1 | One-cycle strobe marking a new result |

## Verification
Several properties are checked on every cycle:
- an invalid code always comes with the flag raised;
- the outputs hold steady between single-cycle update strobes;
- the flag never clears on a result that also changes the code;
- an edge-free stretch longer than the timeout always leaves the outputs at code 7 and flagged.

Other behaviour depends on the history of several windows, and only the bench scenarios can show it. This covers the classification of each rate, the exact ppm boundaries one count either side of each limit, the two-window re-accept rule, the hysteresis band under each select value, and recovery after a lost reference.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    localparam int NUM_RATES = 7;
    localparam int CODE_W    = 3;

    typedef logic [CODE_W-1:0] rate_code_t;

    localparam rate_code_t CODE_NONE = 3'd7;
    localparam longint unsigned PPM_SCALE = 64'd1_000_000;

    // Nominal reference rates in Hz, ascending; index is the output code.
    function automatic longint unsigned rate_hz(input int idx);
        case (idx)
            0:       return 64'd2_000;
            1:       return 64'd8_000;
            2:       return 64'd1_544_000;
            3:       return 64'd2_048_000;
            4:       return 64'd8_192_000;
            5:       return 64'd16_384_000;
            6:       return 64'd19_440_000;
            default: return 64'd1;
        endcase
    endfunction

    // Result state of the monitor.
    typedef struct packed {
        rate_code_t code;
        logic       oor;
        logic       good;
        logic       upd;
    } mon_state_t;

endpackage

// File: rtl/rfm_window_counter.sv
module rfm_window_counter #(
    parameter int WIN_EDGES   = 400,
    parameter int TIMEOUT_CYC = 65536,
    parameter int CNT_W       = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    output logic             win_done,
    output logic             timed_out,
    output logic [CNT_W-1:0] win_cycles
);

    localparam int EDGE_W = (WIN_EDGES > 2) ? $clog2(WIN_EDGES) : 1;
    localparam int GAP_W  = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [GAP_W-1:0]  gap;
        logic              armed;
        logic [EDGE_W-1:0] edges;
        logic [CNT_W-1:0]  cyc;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        win_done  = 1'b0;
        timed_out = 1'b0;

        if (st_q.gap != GAP_W'(TIMEOUT_CYC)) begin
            st_d.gap = st_q.gap + 1'b1;
        end
        if (st_q.armed) begin
            st_d.cyc = st_q.cyc + 1'b1;
        end

        if (ref_edge) begin
            st_d.gap = '0;
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
                st_d.cyc   = CNT_W'(1);
                st_d.edges = '0;
            end else if (st_q.edges == EDGE_W'(WIN_EDGES - 1)) begin
                win_done   = 1'b1;
                st_d.cyc   = CNT_W'(1);
                st_d.edges = '0;
            end else begin
                st_d.edges = st_q.edges + 1'b1;
            end
        end else if (st_q.gap == GAP_W'(TIMEOUT_CYC - 1)) begin
            timed_out  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_cycles = st_q.cyc;

endmodule

// File: rtl/rfm_rate_classifier.sv
module rfm_rate_classifier
    import rfm_pkg::*;
#(
    parameter int MCLK_HZ   = 65_536_000,
    parameter int WIN_EDGES = 400,
    parameter int CNT_W     = 25,
    parameter int TOL_SHIFT = 4
) (
    input  logic [CNT_W-1:0]  win_cycles,
    output rate_code_t        code,
    output logic [63:0]       nominal
);

    localparam longint unsigned SPAN    = longint'(MCLK_HZ) * longint'(WIN_EDGES);
    localparam longint unsigned MIN_NOM = 2 * longint'(WIN_EDGES);

    logic [63:0]          meas;
    logic [63:0]          nom_arr [NUM_RATES];
    logic [NUM_RATES-1:0] hit;

    assign meas = 64'(win_cycles);

    for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
        localparam longint unsigned NOM = SPAN / rate_hz(k);
        logic [63:0] dev;
        assign dev        = (meas > NOM) ? (meas - NOM) : (NOM - meas);
        assign nom_arr[k] = NOM;
        assign hit[k]     = (NOM >= MIN_NOM) && ((dev << TOL_SHIFT) <= NOM);
    end

    always_comb begin
        code    = CODE_NONE;
        nominal = '0;
        for (int k = NUM_RATES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                code    = rate_code_t'(k);
                nominal = nom_arr[k];
            end
        end
    end

endmodule

// File: rtl/rfm_ppm_window.sv
module rfm_ppm_window
    import rfm_pkg::*;
#(
    parameter int LO_PPM_0 = 40,
    parameter int HI_PPM_0 = 52,
    parameter int LO_PPM_1 = 64,
    parameter int HI_PPM_1 = 83,
    parameter int CNT_W    = 25
) (
    input  logic [CNT_W-1:0] win_cycles,
    input  logic [63:0]      nominal,
    input  logic             lim_sel,
    output logic             over_hi,
    output logic             within_lo
);

    localparam longint unsigned LO0 = longint'(LO_PPM_0);
    localparam longint unsigned HI0 = longint'(HI_PPM_0);
    localparam longint unsigned LO1 = longint'(LO_PPM_1);
    localparam longint unsigned HI1 = longint'(HI_PPM_1);

    logic [63:0] meas, dev, lo_lim, hi_lim;

    assign meas   = 64'(win_cycles);
    assign dev    = (meas > nominal) ? (meas - nominal) : (nominal - meas);
    assign lo_lim = lim_sel ? LO1 : LO0;
    assign hi_lim = lim_sel ? HI1 : HI0;

    assign over_hi   = (dev * PPM_SCALE) >  (hi_lim * nominal);
    assign within_lo = (dev * PPM_SCALE) <= (lo_lim * nominal);

endmodule

// File: rtl/ref_rate_monitor.sv
module ref_rate_monitor
    import rfm_pkg::*;
#(
    parameter int MCLK_HZ     = 65_536_000,
    parameter int WIN_EDGES   = 400,
    parameter int TIMEOUT_CYC = MCLK_HZ / 1000,
    parameter int LO_PPM_0    = 40,
    parameter int HI_PPM_0    = 52,
    parameter int LO_PPM_1    = 64,
    parameter int HI_PPM_1    = 83,
    parameter int TOL_SHIFT   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge,
    input  logic       lim_sel,
    output logic [2:0] freq_code,
    output logic       out_of_range,
    output logic       result_upd
);

    localparam int CNT_W = $clog2(longint'(WIN_EDGES) * longint'(TIMEOUT_CYC) + 1);

    logic             win_done, timed_out, over_hi, within_lo;
    logic [CNT_W-1:0] win_cycles;
    rate_code_t       cls_code;
    logic [63:0]      nominal;

    rfm_window_counter #(
        .WIN_EDGES  (WIN_EDGES),
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .CNT_W      (CNT_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_edge  (ref_edge),
        .win_done  (win_done),
        .timed_out (timed_out),
        .win_cycles(win_cycles)
    );

    rfm_rate_classifier #(
        .MCLK_HZ  (MCLK_HZ),
        .WIN_EDGES(WIN_EDGES),
        .CNT_W    (CNT_W),
        .TOL_SHIFT(TOL_SHIFT)
    ) u_classify (
        .win_cycles(win_cycles),
        .code      (cls_code),
        .nominal   (nominal)
    );

    rfm_ppm_window #(
        .LO_PPM_0(LO_PPM_0),
        .HI_PPM_0(HI_PPM_0),
        .LO_PPM_1(LO_PPM_1),
        .HI_PPM_1(HI_PPM_1),
        .CNT_W   (CNT_W)
    ) u_ppm (
        .win_cycles(win_cycles),
        .nominal   (nominal),
        .lim_sel   (lim_sel),
        .over_hi   (over_hi),
        .within_lo (within_lo)
    );

    mon_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;

        if (timed_out) begin
            st_d.code = CODE_NONE;
            st_d.oor  = 1'b1;
            st_d.good = 1'b0;
            st_d.upd  = 1'b1;
        end else if (win_done) begin
            st_d.upd = 1'b1;
            if (cls_code == CODE_NONE) begin
                st_d.code = CODE_NONE;
                st_d.oor  = 1'b1;
                st_d.good = 1'b0;
            end else if (cls_code != st_q.code) begin
                st_d.code = cls_code;
                st_d.oor  = 1'b1;
                st_d.good = within_lo;
            end else if (!st_q.oor) begin
                if (over_hi) begin
                    st_d.oor  = 1'b1;
                    st_d.good = 1'b0;
                end
            end else if (within_lo) begin
                if (st_q.good) begin
                    st_d.oor  = 1'b0;
                    st_d.good = 1'b0;
                end else begin
                    st_d.good = 1'b1;
                end
            end else begin
                st_d.good = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: CODE_NONE, oor: 1'b1, good: 1'b0, upd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_code    = st_q.code;
    assign out_of_range = st_q.oor;
    assign result_upd   = st_q.upd;

endmodule

// File: rtl/rfm_checker.sv
module rfm_checker
    import rfm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 65536
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_edge,
    input logic [2:0] freq_code,
    input logic       out_of_range,
    input logic       result_upd
);

    localparam int GW = $clog2(TIMEOUT_CYC + 2);

    logic [GW-1:0] quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (ref_edge) begin
            quiet <= '0;
        end else if (quiet != GW'(TIMEOUT_CYC + 1)) begin
            quiet <= quiet + 1'b1;
        end
    end

    assert_invalid_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code == CODE_NONE) |-> out_of_range);

    assert_hold_between_updates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !result_upd |-> ($stable(freq_code) && $stable(out_of_range)));

    assert_single_cycle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_upd |=> !result_upd);

    assert_clear_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_of_range) |-> ($stable(freq_code) && result_upd));

    assert_lost_reference_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet == GW'(TIMEOUT_CYC + 1)) |-> (freq_code == CODE_NONE && out_of_range));

endmodule

bind ref_rate_monitor rfm_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rfm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_edge    (ref_edge),
    .freq_code   (freq_code),
    .out_of_range(out_of_range),
    .result_upd  (result_upd)
);

// File: tb/test_ref_rate_monitor.sv
module test_ref_rate_monitor;

    localparam int WIN_A = 400;
    localparam int WIN_B = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_a = 1'b0, ref_b = 1'b0, sel_a = 1'b0;
    logic [2:0] code_a, code_b;
    logic       oor_a, oor_b, upd_a, upd_b;

    always #5 clk = ~clk;

    ref_rate_monitor i_ref_rate_monitor (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_a), .lim_sel(sel_a),
        .freq_code(code_a), .out_of_range(oor_a), .result_upd(upd_a));

    ref_rate_monitor #(.MCLK_HZ(1_000_000), .WIN_EDGES(WIN_B)) i_ref_rate_monitor_slow (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_b), .lim_sel(1'b0),
        .freq_code(code_b), .out_of_range(oor_b), .result_upd(upd_b));

    typedef struct {
        int    code;
        int    oor;
        string tag;
    } exp_t;

    exp_t q_a[$];
    exp_t q_b[$];
    int   n_chk = 0, n_bad = 0;
    bit   ended = 1'b0;

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic expect_res(input int which, input int code, input int oor, input string tag);
        exp_t e;
        e.code = code; e.oor = oor; e.tag = tag;
        if (which == 0) q_a.push_back(e); else q_b.push_back(e);
    endtask

    task automatic drive(input int which, input bit v);
        @(negedge clk);
        if (which == 0) ref_a = v; else ref_b = v;
    endtask

    // Integer-period window; the final period is stretched by delta cycles.
    task automatic int_window(input int which, input int per, input int delta);
        int win = (which == 0) ? WIN_A : WIN_B;
        for (int i = 0; i < win; i++) begin
            int p = (i == win - 1) ? per + delta : per;
            for (int c = 0; c < p - 1; c++) drive(which, 1'b0);
            drive(which, 1'b1);
        end
    endtask

    // Fractional-rate window from a phase accumulator (instance A only).
    task automatic frac_window(input longint f_hz, input longint mclk);
        longint acc = 0;
        int     n = 0;
        while (n < WIN_A) begin
            acc += f_hz;
            if (acc >= mclk) begin
                acc -= mclk;
                n++;
                drive(0, 1'b1);
            end else begin
                drive(0, 1'b0);
            end
        end
    endtask

    task automatic compare(input int which, input int code, input int oor);
        exp_t e;
        string who = (which == 0) ? "A" : "B";
        if ((which == 0 && q_a.size() == 0) || (which == 1 && q_b.size() == 0)) begin
            check(1'b0, $sformatf("R4 %s unexpected update: code %0d oor %0d, expected no update", who, code, oor));
        end else begin
            e = (which == 0) ? q_a.pop_front() : q_b.pop_front();
            check(code == e.code && oor == e.oor,
                  $sformatf("%s %s: code %0d oor %0d, expected code %0d oor %0d",
                            e.tag, who, code, oor, e.code, e.oor));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (upd_a) compare(0, int'(code_a), int'(oor_a));
            if (upd_b) compare(1, int'(code_b), int'(oor_b));
        end
    end

    task automatic run_a();
        drive(0, 1'b1);                        // opens first window
        expect_res(0, 3, 1, "R7 first 2.048M window");       int_window(0, 32, 0);
        expect_res(0, 3, 0, "R6 second clean window clears"); int_window(0, 32, 0);
        expect_res(0, 3, 1, "R5 +78ppm rejected sel0");       int_window(0, 32, 1);
        expect_res(0, 3, 1, "R6 one clean window not enough"); int_window(0, 32, 0);
        expect_res(0, 3, 0, "R6 two clean windows clear");    int_window(0, 32, 0);
        sel_a = 1'b1;
        expect_res(0, 3, 0, "R9 +78ppm kept under sel1");     int_window(0, 32, 1);
        expect_res(0, 3, 1, "R5 +156ppm rejected sel1");      int_window(0, 32, 2);
        expect_res(0, 3, 1, "R6 +78ppm band no re-accept");   int_window(0, 32, 1);
        expect_res(0, 5, 1, "R2 16.384M code 5");             int_window(0, 4, 0);
        expect_res(0, 5, 0, "R6 16.384M clears");             int_window(0, 4, 0);
        expect_res(0, 4, 1, "R2 8.192M code 4");              int_window(0, 8, 0);
        expect_res(0, 6, 1, "R2 19.44M code 6");              frac_window(64'd19_440_000, 64'd65_536_000);
        drive(0, 1'b0);
    endtask

    task automatic run_b();
        drive(1, 1'b1);
        expect_res(1, 0, 1, "R2 2kHz code 0");        int_window(1, 500, 0);
        expect_res(1, 0, 0, "R6 2kHz clears");        int_window(1, 500, 0);
        expect_res(1, 7, 1, "R3 unmatched rate");     int_window(1, 300, 0);
        expect_res(1, 1, 1, "R2 8kHz code 1");        int_window(1, 125, 0);
        expect_res(1, 1, 0, "R6 8kHz clears");        int_window(1, 125, 0);
        expect_res(1, 7, 1, "R8 timeout");
        for (int c = 0; c < 1100; c++) drive(1, 1'b0);
        drive(1, 1'b1);                        // restart edge: no result of its own
        expect_res(1, 0, 1, "R8 recovery window");    int_window(1, 500, 0);
        expect_res(1, 7, 1, "R8 final timeout");
        for (int c = 0; c < 1100; c++) drive(1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(code_a == 3'd7 && oor_a && !upd_a,
              $sformatf("R1 A reset: code %0d oor %0d upd %0d, expected 7 1 0", code_a, oor_a, upd_a));
        check(code_b == 3'd7 && oor_b && !upd_b,
              $sformatf("R1 B reset: code %0d oor %0d upd %0d, expected 7 1 0", code_b, oor_b, upd_b));
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(code_a == 3'd7 && oor_a && !upd_a,
              $sformatf("R1 A idle after reset: code %0d oor %0d upd %0d, expected 7 1 0", code_a, oor_a, upd_a));
        fork
            run_a();
            run_b();
        join
        repeat (20) @(negedge clk);
        check(q_a.size() == 0, $sformatf("R4 A results missing: %0d, expected 0", q_a.size()));
        check(q_b.size() == 0, $sformatf("R4 B results missing: %0d, expected 0", q_b.size()));
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            check(1'b0, "R4 watchdog expired: run incomplete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule